// File: doc/BRIEF.md
# Register Bank Fault Exception Entry Sequencer

This block carries out exception entry after the register save-area controller reports a fault: either an attempted save when every bank slot is already full (overflow) or an attempted restore when no slot holds data (underflow). One fault request is taken at a time. For each request the sequencer works through four steps:

- It reads the handler start address from the vector table slot that belongs to the fault type.
- It pushes the current status word onto the stack.
- It pushes a return PC onto the stack. Which PC is pushed depends on the fault type.
- It hands the handler address, the updated status word and the lowered stack pointer back to the core, and marks that moment with a single-cycle `done` pulse.

The fault request uses a valid/ready handshake. `req_ready` is high only while the sequencer is idle. The request fields are captured on the edge where `req_valid` and `req_ready` are both high. While a request is being processed, `req_ready` stays low, so the upstream logic must hold or retry.

The memory read port and the memory write port each use valid/ack. The sequencer raises `rd_valid` or `wr_valid` and holds the address and data stable until memory returns `rd_ack` or `wr_ack`. Memory can therefore stall any step for any number of cycles. On the read port, `rd_data` is taken in the cycle that `rd_ack` is high.

Top module: `bank_fault_entry`

## Requirements
- R1: After reset, `req_ready` is 1 and `rd_valid`, `wr_valid` and `done` are 0.
- R2: The first memory access is a read at `vbr + 4*N`, where N is OVF_VEC (default 10) for an overflow (`req_is_ovf`=1) and UDF_VEC (default 11) for an underflow. `rd_valid` and `rd_addr` are held until `rd_ack`.
- R3: The second access is a write of the captured `cur_sr` to address `cur_sp - 4`.
- R4: The third access is a write to `cur_sp - 8`. Its data is `req_next_pc` for an overflow and `req_fault_pc` for an underflow.
- R5: On overflow, `new_sr` equals the captured SR with bits [7:4] (the interrupt mask) replaced by `req_prio`. On underflow, `new_sr` equals the captured SR unchanged.
- R6: `done` is high for exactly one cycle. It rises in the cycle after the third access is acknowledged. From that cycle on, `new_pc` holds the `rd_data` returned by the vector read and `new_sp` holds `cur_sp - 8`.
- R7: From the accepting edge through the `done` cycle, `req_ready` is 0. A request presented in that window has no effect on any memory access or on `new_pc`, `new_sr` and `new_sp`. `req_ready` returns to 1 in the cycle after `done`.
- R8: At most one of `rd_valid` and `wr_valid` is high at a time. A write request holds `wr_addr` and `wr_data` stable until `wr_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Fault request present |
| req_ready | output | 1 | Sequencer idle and able to take a request |
| req_is_ovf | input | 1 | 1 = overflow fault, 0 = underflow fault |
| req_next_pc | input | 32 | Address of the instruction after the last one executed |
| req_fault_pc | input | 32 | Address of the faulting restore instruction |
| req_prio | input | 4 | Priority level of the interrupt that caused the overflow |
| cur_sr | input | 32 | Current status word |
| cur_sp | input | 32 | Current stack pointer |
| vbr | input | 32 | Vector table base address |
| rd_valid | output | 1 | Vector read request |
| rd_addr | output | 32 | Vector read address |
| rd_ack | input | 1 | Read accepted; data valid this cycle |
| rd_data | input | 32 | Read data |
| wr_valid | output | 1 | Stack write request |
| wr_addr | output | 32 | Stack write address |
| wr_data | output | 32 | Stack write data |
| wr_ack | input | 1 | Write accepted |
| done | output | 1 | One-cycle pulse: entry complete |
| new_pc | output | 32 | Handler start address |
| new_sr | output | 32 | Updated status word |
| new_sp | output | 32 | Updated stack pointer |

## Verification
Two events can fall in the same cycle: the `done` pulse of one entry, and a new fault request. The bench provokes this by keeping `req_valid` asserted from acceptance through the `done` cycle, with every request field changed to unrelated values in the meantime.

It then judges the result in three ways:
- The stack writes and the reported results must still match the originally captured request.
- `req_ready` must read 0 in the `done` cycle.
- The next transaction must start cleanly from idle.

The sweep covers both fault types, every priority value, and memory wait states of zero to two cycles.

// File: rtl/bfe_pkg.sv
package bfe_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_PUSH_SR,
    ST_PUSH_PC,
    ST_DONE
  } bfe_state_e;
endpackage

// File: rtl/bfe_ctx.sv
module bfe_ctx #(
  parameter int AW         = 32,
  parameter int MASK_W     = 4,
  parameter int MASK_LSB   = 4,
  parameter int OVF_VEC    = 10,
  parameter int UDF_VEC    = 11,
  parameter int WORD_BYTES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              is_ovf,
  input  logic [AW-1:0]     next_pc,
  input  logic [AW-1:0]     fault_pc,
  input  logic [MASK_W-1:0] prio,
  input  logic [AW-1:0]     sr,
  input  logic [AW-1:0]     sp,
  input  logic [AW-1:0]     vbr,
  output logic [AW-1:0]     vec_addr,
  output logic [AW-1:0]     sr_addr,
  output logic [AW-1:0]     pc_addr,
  output logic [AW-1:0]     sr_word,
  output logic [AW-1:0]     ret_pc,
  output logic [AW-1:0]     sr_next
);
  localparam logic [AW-1:0] OVF_OFS = AW'(OVF_VEC * WORD_BYTES);
  localparam logic [AW-1:0] UDF_OFS = AW'(UDF_VEC * WORD_BYTES);
  localparam logic [AW-1:0] STEP    = AW'(WORD_BYTES);

  logic              ovf_q;
  logic [AW-1:0]     ret_q, sr_q, sp_q, vbr_q;
  logic [MASK_W-1:0] prio_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_q  <= 1'b0;
      ret_q  <= '0;
      sr_q   <= '0;
      sp_q   <= '0;
      vbr_q  <= '0;
      prio_q <= '0;
    end else if (load) begin
      ovf_q  <= is_ovf;
      ret_q  <= is_ovf ? next_pc : fault_pc;
      sr_q   <= sr;
      sp_q   <= sp;
      vbr_q  <= vbr;
      prio_q <= prio;
    end
  end

  assign vec_addr = vbr_q + (ovf_q ? OVF_OFS : UDF_OFS);
  assign sr_addr  = sp_q - STEP;
  assign pc_addr  = sp_q - (STEP + STEP);
  assign sr_word  = sr_q;
  assign ret_pc   = ret_q;

  always_comb begin
    sr_next = sr_q;
    if (ovf_q) sr_next[MASK_LSB +: MASK_W] = prio_q;
  end
endmodule

// File: rtl/bfe_fsm.sv
module bfe_fsm
  import bfe_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  output logic          load,
  input  logic [AW-1:0] vec_addr,
  input  logic [AW-1:0] sr_addr,
  input  logic [AW-1:0] pc_addr,
  input  logic [AW-1:0] sr_word,
  input  logic [AW-1:0] ret_pc,
  input  logic [AW-1:0] sr_next,
  output logic          rd_valid,
  output logic [AW-1:0] rd_addr,
  input  logic          rd_ack,
  input  logic [AW-1:0] rd_data,
  output logic          wr_valid,
  output logic [AW-1:0] wr_addr,
  output logic [AW-1:0] wr_data,
  input  logic          wr_ack,
  output logic          done,
  output logic [AW-1:0] new_pc,
  output logic [AW-1:0] new_sr,
  output logic [AW-1:0] new_sp
);
  bfe_state_e    state_q;
  logic [AW-1:0] handler_q;

  assign req_ready = (state_q == ST_IDLE);
  assign load      = req_ready && req_valid;
  assign rd_valid  = (state_q == ST_FETCH);
  assign rd_addr   = vec_addr;
  assign wr_valid  = (state_q == ST_PUSH_SR) || (state_q == ST_PUSH_PC);
  assign wr_addr   = (state_q == ST_PUSH_PC) ? pc_addr : sr_addr;
  assign wr_data   = (state_q == ST_PUSH_PC) ? ret_pc  : sr_word;
  assign done      = (state_q == ST_DONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      handler_q <= '0;
      new_pc    <= '0;
      new_sr    <= '0;
      new_sp    <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE:    if (load) state_q <= ST_FETCH;
        ST_FETCH:   if (rd_ack) begin
                      handler_q <= rd_data;
                      state_q   <= ST_PUSH_SR;
                    end
        ST_PUSH_SR: if (wr_ack) state_q <= ST_PUSH_PC;
        ST_PUSH_PC: if (wr_ack) begin
                      new_pc  <= handler_q;
                      new_sr  <= sr_next;
                      new_sp  <= pc_addr;
                      state_q <= ST_DONE;
                    end
        ST_DONE:    state_q <= ST_IDLE;
        default:    state_q <= ST_IDLE;
      endcase
    end
  end

  AST_ONE_PORT: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_valid && wr_valid)); // R8
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !rd_ack |=> rd_valid && $stable(rd_addr)); // R2
  AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ack |=> wr_valid && $stable(wr_addr) && $stable(wr_data)); // R8
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R6
  AST_BUSY_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !req_ready); // R7
  AST_READY_AFTER: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> req_ready); // R7
  AST_READ_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> rd_valid && !wr_valid); // R2
endmodule

// File: rtl/bank_fault_entry.sv
module bank_fault_entry #(
  parameter int AW         = 32,
  parameter int MASK_W     = 4,
  parameter int MASK_LSB   = 4,
  parameter int OVF_VEC    = 10,
  parameter int UDF_VEC    = 11,
  parameter int WORD_BYTES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_is_ovf,
  input  logic [AW-1:0]     req_next_pc,
  input  logic [AW-1:0]     req_fault_pc,
  input  logic [MASK_W-1:0] req_prio,
  input  logic [AW-1:0]     cur_sr,
  input  logic [AW-1:0]     cur_sp,
  input  logic [AW-1:0]     vbr,
  output logic              rd_valid,
  output logic [AW-1:0]     rd_addr,
  input  logic              rd_ack,
  input  logic [AW-1:0]     rd_data,
  output logic              wr_valid,
  output logic [AW-1:0]     wr_addr,
  output logic [AW-1:0]     wr_data,
  input  logic              wr_ack,
  output logic              done,
  output logic [AW-1:0]     new_pc,
  output logic [AW-1:0]     new_sr,
  output logic [AW-1:0]     new_sp
);
  logic          load;
  logic [AW-1:0] vec_addr, sr_addr, pc_addr, sr_word, ret_pc, sr_next;

  bfe_ctx #(
    .AW(AW), .MASK_W(MASK_W), .MASK_LSB(MASK_LSB),
    .OVF_VEC(OVF_VEC), .UDF_VEC(UDF_VEC), .WORD_BYTES(WORD_BYTES)
  ) u_ctx (
    .clk(clk), .rst_n(rst_n), .load(load),
    .is_ovf(req_is_ovf), .next_pc(req_next_pc), .fault_pc(req_fault_pc),
    .prio(req_prio), .sr(cur_sr), .sp(cur_sp), .vbr(vbr),
    .vec_addr(vec_addr), .sr_addr(sr_addr), .pc_addr(pc_addr),
    .sr_word(sr_word), .ret_pc(ret_pc), .sr_next(sr_next)
  );

  bfe_fsm #(.AW(AW)) u_fsm (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .load(load),
    .vec_addr(vec_addr), .sr_addr(sr_addr), .pc_addr(pc_addr),
    .sr_word(sr_word), .ret_pc(ret_pc), .sr_next(sr_next),
    .rd_valid(rd_valid), .rd_addr(rd_addr), .rd_ack(rd_ack), .rd_data(rd_data),
    .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data), .wr_ack(wr_ack),
    .done(done), .new_pc(new_pc), .new_sr(new_sr), .new_sp(new_sp)
  );
endmodule

// File: tb/test_bank_fault_entry.sv
`timescale 1ns/1ps
module test_bank_fault_entry;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_is_ovf = 1'b0;
  logic [31:0] req_next_pc = '0, req_fault_pc = '0, cur_sr = '0, cur_sp = '0, vbr = '0;
  logic [3:0]  req_prio = '0;
  logic        rd_ack = 1'b0, wr_ack = 1'b0;
  logic [31:0] rd_data = '0;
  logic        req_ready, rd_valid, wr_valid, done;
  logic [31:0] rd_addr, wr_addr, wr_data, new_pc, new_sr, new_sp;

  int n_run = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  bank_fault_entry i_bank_fault_entry (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_is_ovf(req_is_ovf),
    .req_next_pc(req_next_pc), .req_fault_pc(req_fault_pc), .req_prio(req_prio),
    .cur_sr(cur_sr), .cur_sp(cur_sp), .vbr(vbr),
    .rd_valid(rd_valid), .rd_addr(rd_addr), .rd_ack(rd_ack), .rd_data(rd_data),
    .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data), .wr_ack(wr_ack),
    .done(done), .new_pc(new_pc), .new_sr(new_sr), .new_sp(new_sp)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic scramble();
    req_is_ovf   = ~req_is_ovf;
    req_next_pc  = 32'hDEAD_0000;
    req_fault_pc = 32'hBEEF_0000;
    req_prio     = ~req_prio;
    cur_sr       = 32'hFFFF_FFFF;
    cur_sp       = 32'h0000_0100;
    vbr          = 32'h7000_0000;
  endtask

  initial begin
    repeat (25000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 req_ready", {31'b0, req_ready}, 32'd1);
    chk("R1 rd_valid",  {31'b0, rd_valid},  32'd0);
    chk("R1 wr_valid",  {31'b0, wr_valid},  32'd0);
    chk("R1 done",      {31'b0, done},      32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 idle after release", {31'b0, req_ready}, 32'd1);

    for (int o = 0; o < 2; o++) begin
      for (int p = 0; p < 16; p++) begin
        automatic logic        ovf  = o[0];
        automatic logic [3:0]  pr   = p[3:0];
        automatic logic [31:0] sr   = 32'h1234_5600 | (32'((p * 7 + o * 3) % 16) << 4) | 32'(p);
        automatic logic [31:0] sp   = 32'h0000_8000 + 32'(p) * 32'h100 + 32'(o) * 32'h10;
        automatic logic [31:0] vb   = 32'h1000_0000 + 32'(p) * 32'h40;
        automatic logic [31:0] npc  = 32'h4000_0000 + 32'(p) * 16 + 2;
        automatic logic [31:0] fpc  = 32'h5000_0000 + 32'(p) * 16;
        automatic logic [31:0] hnd  = 32'hC000_0000 | (32'(p) << 8) | 32'(o);
        automatic int          ws   = (p + o) % 3;
        automatic bit          hold = p[0];
        automatic logic [31:0] exp_sr = ovf ? ((sr & ~32'h0000_00F0) | (32'(pr) << 4)) : sr;

        req_is_ovf = ovf; req_prio = pr; cur_sr = sr; cur_sp = sp; vbr = vb;
        req_next_pc = npc; req_fault_pc = fpc; req_valid = 1'b1;
        chk("R7 ready in idle", {31'b0, req_ready}, 32'd1);
        @(negedge clk);
        if (hold) scramble(); else req_valid = 1'b0;
        // fetch step
        chk("R7 busy after accept", {31'b0, req_ready}, 32'd0);
        chk("R2 rd_valid", {31'b0, rd_valid}, 32'd1);
        chk("R8 no write during read", {31'b0, wr_valid}, 32'd0);
        chk("R2 vector addr", rd_addr, vb + (ovf ? 32'd40 : 32'd44));
        repeat (ws) begin
          @(negedge clk);
          chk("R2 rd held", {31'b0, rd_valid}, 32'd1);
        end
        rd_ack = 1'b1; rd_data = hnd;
        @(negedge clk);
        rd_ack = 1'b0; rd_data = 32'h0BAD_0BAD;
        chk("R3 wr_valid sr", {31'b0, wr_valid}, 32'd1);
        chk("R8 read dropped", {31'b0, rd_valid}, 32'd0);
        chk("R3 sr addr", wr_addr, sp - 32'd4);
        chk("R3 sr data", wr_data, sr);
        repeat (ws) begin
          @(negedge clk);
          chk("R8 sr write held", wr_addr, sp - 32'd4);
        end
        wr_ack = 1'b1;
        @(negedge clk);
        wr_ack = 1'b0;
        chk("R4 wr_valid pc", {31'b0, wr_valid}, 32'd1);
        chk("R4 pc addr", wr_addr, sp - 32'd8);
        chk("R4 pc data", wr_data, ovf ? npc : fpc);
        chk("R6 no early done", {31'b0, done}, 32'd0);
        repeat (ws) begin
          @(negedge clk);
          chk("R8 pc write held", wr_data, ovf ? npc : fpc);
        end
        wr_ack = 1'b1;
        @(negedge clk);
        wr_ack = 1'b0;
        chk("R6 done", {31'b0, done}, 32'd1);
        chk("R7 busy at done", {31'b0, req_ready}, 32'd0);
        chk("R6 new_pc", new_pc, hnd);
        chk("R6 new_sp", new_sp, sp - 32'd8);
        chk("R5 new_sr", new_sr, exp_sr);
        req_valid = 1'b0;
        @(negedge clk);
        chk("R6 done one cycle", {31'b0, done}, 32'd0);
        chk("R7 ready again", {31'b0, req_ready}, 32'd1);
        chk("R7 no stray read", {31'b0, rd_valid}, 32'd0);
        chk("R7 results held", new_pc, hnd);
      end
    end

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule